// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block sits inside a DRAM controller and decides when the memory device is put into a low-power state and which state to use. It watches an access-request level from the controller front end. After the last transfer it counts idle cycles against a programmable delay, then issues one of three entry commands: self refresh, power-down or deep power-down. It then lowers CKE and, where the state calls for it, stops the memory clock.

When a new access arrives, the device is brought back to active. The access is stalled with `busy_o` until a modelled exit latency has passed. Self refresh and power-down are entered again by the same idle rule once traffic stops. Deep power-down is left only when software moves the mode selector away from it.

Two overrides act on the outputs whatever the sequencer state. A clock-freeze bit holds the memory clock off. A power-off bit forces CKE low and stalls access.

Top module: `lp_mode_seq`

## Requirements
- R1: After reset the sequencer is active. `cke_o`=1, `mem_clk_en_o`=1, every command strobe is 0, and `busy_o`=0 while `acc_req_i` is high.
- R2: With `mode_i`=0 no entry command is ever issued and `cke_o` stays 1, however long the idle time.
- R3: Counted from the first rising edge at which `acc_req_i` is sampled low, the entry strobe appears after edge N+1. N is 0 for `timeout_i`=0, 64 for 1, and 128 for 2 and for 3.
- R4: A request sampled high during the idle countdown restarts it from zero, and no entry strobe follows that edge.
- R5: `mode_i`=1 selects self refresh. `sr_entry_o` pulses for one cycle, and in the next cycle `cke_o`=0 and `mem_clk_en_o`=0.
- R6: `mode_i`=2 selects power-down. `pd_entry_o` pulses for one cycle, and in the next cycle `cke_o`=0 while `mem_clk_en_o` stays 1.
- R7: In self refresh or power-down, a request sampled high produces the matching exit strobe after that edge, with `cke_o` still 0. `cke_o` returns to 1 after the following edge.
- R8: `busy_o` falls after edge L+2 counted from the wake trigger. L is FAST_EXIT_CYC (2), except on a power-down exit with `slow_exit_i`=1, where it is SLOW_EXIT_CYC (6).
- R9: `mode_i`=3 selects deep power-down. `dpd_entry_o` pulses, then `cke_o`=0 and `mem_clk_en_o`=0. Requests are stalled with `busy_o`=1 and cause no exit. Changing `mode_i` away from 3 produces `dpd_exit_o` after the next edge, followed by the normal wake.
- R10: While `clk_freeze_i`=1, `mem_clk_en_o`=0.
- R11: While `pwr_off_i`=1, `cke_o`=0 and `busy_o` follows `acc_req_i`.
- R12: Every strobe lasts one cycle. Apart from power-off, `cke_o` falls only in the cycle after an entry strobe and rises only in the cycle after an exit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 off, 1 self refresh, 2 power-down, 3 deep power-down |
| timeout_i | input | 2 | Idle delay select: 0, 64, 128, 128 cycles |
| slow_exit_i | input | 1 | Slow exit from power-down |
| clk_freeze_i | input | 1 | Hold memory clock off |
| pwr_off_i | input | 1 | Power-off: force CKE low, stall access |
| acc_req_i | input | 1 | Access pending or in progress |
| busy_o | output | 1 | Access stalled while the device is not active |
| sr_entry_o | output | 1 | Self-refresh entry strobe |
| sr_exit_o | output | 1 | Self-refresh exit strobe |
| pd_entry_o | output | 1 | Power-down entry strobe |
| pd_exit_o | output | 1 | Power-down exit strobe |
| dpd_entry_o | output | 1 | Deep power-down entry strobe |
| dpd_exit_o | output | 1 | Deep power-down exit strobe |
| cke_o | output | 1 | Clock enable to the device |
| mem_clk_en_o | output | 1 | Memory clock gate enable |

## Verification
Inputs change one time unit after a rising edge, and outputs are sampled at that same point. An output therefore reflects the state register written at the edge just passed. Entry timing is measured by counting edges from the one that first samples the request low, and the expected count is N+1. The exit strobe is due after the first edge following the trigger, CKE after the second, and the `busy_o` release after edge L+2. The bench derives L from the mode and the exit-speed bit. The combinational overrides (`busy_o` on a pending request, clock freeze, power-off) are checked at the same sampling point in which they are applied.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [3:0] {
    ST_ACTIVE, ST_SR_ENT, ST_SR, ST_SR_EXIT,
    ST_PD_ENT, ST_PD, ST_PD_EXIT,
    ST_DPD_ENT, ST_DPD, ST_DPD_EXIT, ST_WAKE
  } lp_state_e;

  typedef enum logic [1:0] {
    LP_OFF = 2'd0, LP_SR = 2'd1, LP_PD = 2'd2, LP_DPD = 2'd3
  } lp_mode_e;
endpackage

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
  parameter int SHORT_IDLE = 64,
  parameter int LONG_IDLE  = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] timeout_i,
  output logic       hit_o
);
  localparam int CNT_W = $clog2(LONG_IDLE + 1);

  logic [CNT_W-1:0] cnt_q, thr;

  always_comb begin
    unique case (timeout_i)
      2'd0:    thr = '0;
      2'd1:    thr = CNT_W'(SHORT_IDLE);
      default: thr = CNT_W'(LONG_IDLE);  // 3 reserved, treated as long
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && (cnt_q >= thr);
endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer #(
  parameter int FAST_EXIT_CYC = 2,
  parameter int SLOW_EXIT_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic slow_i,
  output logic done_o
);
  localparam int MAX_LAT = (SLOW_EXIT_CYC > FAST_EXIT_CYC) ? SLOW_EXIT_CYC : FAST_EXIT_CYC;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= slow_i ? LAT_W'(SLOW_EXIT_CYC - 1) : LAT_W'(FAST_EXIT_CYC - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R8
  wake_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o || (!slow_i && FAST_EXIT_CYC == 1) || (slow_i && SLOW_EXIT_CYC == 1));
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       acc_req_i,
  input  logic       idle_hit_i,
  input  logic       wake_done_i,
  output lp_state_e  state_o,
  output logic       sr_entry_o,
  output logic       sr_exit_o,
  output logic       pd_entry_o,
  output logic       pd_exit_o,
  output logic       dpd_entry_o,
  output logic       dpd_exit_o,
  output logic       cke_o,
  output logic       clk_en_o,
  output logic       wake_start_o
);
  lp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ACTIVE:
        if (idle_hit_i && !acc_req_i) begin
          unique case (mode_i)
            LP_SR:   st_d = ST_SR_ENT;
            LP_PD:   st_d = ST_PD_ENT;
            LP_DPD:  st_d = ST_DPD_ENT;
            default: st_d = ST_ACTIVE;
          endcase
        end
      ST_SR_ENT:   st_d = ST_SR;
      ST_SR:       if (acc_req_i) st_d = ST_SR_EXIT;
      ST_SR_EXIT:  st_d = ST_WAKE;
      ST_PD_ENT:   st_d = ST_PD;
      ST_PD:       if (acc_req_i) st_d = ST_PD_EXIT;
      ST_PD_EXIT:  st_d = ST_WAKE;
      ST_DPD_ENT:  st_d = ST_DPD;
      ST_DPD:      if (mode_i != LP_DPD) st_d = ST_DPD_EXIT;
      ST_DPD_EXIT: st_d = ST_WAKE;
      ST_WAKE:     if (wake_done_i) st_d = ST_ACTIVE;
      default:     st_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_ACTIVE;
    else         st_q <= st_d;
  end

  assign state_o      = st_q;
  assign sr_entry_o   = (st_q == ST_SR_ENT);
  assign sr_exit_o    = (st_q == ST_SR_EXIT);
  assign pd_entry_o   = (st_q == ST_PD_ENT);
  assign pd_exit_o    = (st_q == ST_PD_EXIT);
  assign dpd_entry_o  = (st_q == ST_DPD_ENT);
  assign dpd_exit_o   = (st_q == ST_DPD_EXIT);
  assign wake_start_o = sr_exit_o || pd_exit_o || dpd_exit_o;
  // CKE stays high in entry cycles and low in exit cycles
  assign cke_o    = !(st_q inside {ST_SR, ST_SR_EXIT, ST_PD, ST_PD_EXIT, ST_DPD, ST_DPD_EXIT});
  assign clk_en_o = !(st_q inside {ST_SR, ST_DPD});

  logic any_entry;
  assign any_entry = sr_entry_o || pd_entry_o || dpd_entry_o;

  // R4
  req_blocks_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_i |=> !any_entry);
  // R2
  off_mode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACTIVE && mode_i == LP_OFF) |=> !any_entry);
  // R7
  req_wakes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && (st_q == ST_SR || st_q == ST_PD)) |=> (sr_exit_o || pd_exit_o) && !cke_o);
  // R9
  dpd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DPD && mode_i == LP_DPD) |=> !dpd_exit_o && !cke_o && !clk_en_o);
  // R12
  entry_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_entry |=> !any_entry && !cke_o);
endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
  import lp_seq_pkg::*;
#(
  parameter int SHORT_IDLE    = 64,
  parameter int LONG_IDLE     = 128,
  parameter int FAST_EXIT_CYC = 2,
  parameter int SLOW_EXIT_CYC = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic [1:0] timeout_i,
  input  logic       slow_exit_i,
  input  logic       clk_freeze_i,
  input  logic       pwr_off_i,
  input  logic       acc_req_i,
  output logic       busy_o,
  output logic       sr_entry_o,
  output logic       sr_exit_o,
  output logic       pd_entry_o,
  output logic       pd_exit_o,
  output logic       dpd_entry_o,
  output logic       dpd_exit_o,
  output logic       cke_o,
  output logic       mem_clk_en_o
);
  lp_state_e state;
  logic idle_hit, wake_done, wake_start, fsm_cke, fsm_clk_en;

  lp_idle_timer #(.SHORT_IDLE(SHORT_IDLE), .LONG_IDLE(LONG_IDLE)) idle_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state == ST_ACTIVE && !acc_req_i),
    .timeout_i(timeout_i),
    .hit_o    (idle_hit)
  );

  lp_wake_timer #(.FAST_EXIT_CYC(FAST_EXIT_CYC), .SLOW_EXIT_CYC(SLOW_EXIT_CYC)) wake_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wake_start),
    .slow_i (pd_exit_o && slow_exit_i),  // slow exit applies to power-down only
    .done_o (wake_done)
  );

  lp_fsm fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .acc_req_i   (acc_req_i),
    .idle_hit_i  (idle_hit),
    .wake_done_i (wake_done),
    .state_o     (state),
    .sr_entry_o  (sr_entry_o),
    .sr_exit_o   (sr_exit_o),
    .pd_entry_o  (pd_entry_o),
    .pd_exit_o   (pd_exit_o),
    .dpd_entry_o (dpd_entry_o),
    .dpd_exit_o  (dpd_exit_o),
    .cke_o       (fsm_cke),
    .clk_en_o    (fsm_clk_en),
    .wake_start_o(wake_start)
  );

  assign cke_o        = fsm_cke && !pwr_off_i;
  assign mem_clk_en_o = fsm_clk_en && !clk_freeze_i;
  assign busy_o       = acc_req_i && (state != ST_ACTIVE || pwr_off_i);

  // R12
  cke_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cke_o) && !pwr_off_i && !$past(pwr_off_i))
      |-> $past(sr_entry_o || pd_entry_o || dpd_entry_o));
  // R12
  cke_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cke_o) && !pwr_off_i && !$past(pwr_off_i))
      |-> $past(sr_exit_o || pd_exit_o || dpd_exit_o));
  // R5
  sr_clk_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_entry_o |=> !mem_clk_en_o);
  // R8
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && !pwr_off_i && $past(wake_start)) |-> busy_o);
endmodule

// File: tb/lp_mode_seq_tb_top.sv
module lp_mode_seq_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode = 2'd0, tmo = 2'd0;
  logic slow = 1'b0, frz = 1'b0, poff = 1'b0, req = 1'b1;
  logic busy, sr_en, sr_ex, pd_en, pd_ex, dpd_en, dpd_ex, cke, clk_en;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lp_mode_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .timeout_i(tmo),
    .slow_exit_i(slow), .clk_freeze_i(frz), .pwr_off_i(poff), .acc_req_i(req),
    .busy_o(busy), .sr_entry_o(sr_en), .sr_exit_o(sr_ex), .pd_entry_o(pd_en),
    .pd_exit_o(pd_ex), .dpd_entry_o(dpd_en), .dpd_exit_o(dpd_ex),
    .cke_o(cke), .mem_clk_en_o(clk_en)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [2:0] ent_vec();
    return {sr_en, pd_en, dpd_en};
  endfunction
  function automatic logic [2:0] ext_vec();
    return {sr_ex, pd_ex, dpd_ex};
  endfunction
  function automatic logic [2:0] kind(input logic [1:0] m);
    return (m == 2'd1) ? 3'b100 : (m == 2'd2) ? 3'b010 : (m == 2'd3) ? 3'b001 : 3'b000;
  endfunction

  // counts edges after a trigger until busy drops; checks exit strobe and CKE
  task automatic wake_seq(input logic [2:0] exp_kind, input int lat);
    int n;
    tick(); n = 1;
    chk(ext_vec() == exp_kind, "R7 exit strobe", ext_vec(), exp_kind);
    chk(cke == 1'b0, "R7 cke low in exit cycle", cke, 0);
    tick(); n = 2;
    chk(cke == 1'b1, "R7 cke back high", cke, 1);
    chk(ext_vec() == 3'b000, "R12 exit strobe one cycle", ext_vec(), 0);
    while (busy && n < 50) begin tick(); n++; end
    chk(n == lat + 2, "R8 busy release edge", n, lat + 2);
  endtask

  initial begin
    int n, thr, lat;
    #1;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick(); tick();
    // R1
    chk(cke == 1'b1, "R1 reset cke", cke, 1);
    chk(clk_en == 1'b1, "R1 reset clk_en", clk_en, 1);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk({ent_vec(), ext_vec()} == 6'd0, "R1 reset strobes", {ent_vec(), ext_vec()}, 0);

    // R2: mode off, long idle
    mode = 2'd0; tmo = 2'd0; req = 1'b0;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (ent_vec() != 3'b000 || cke != 1'b1) n++;
    end
    chk(n == 0, "R2 no entry when off", n, 0);
    req = 1'b1; tick();

    // sweep modes, timeouts, exit speed
    for (int m = 1; m < 4; m++) begin
      for (int t = 0; t < 4; t++) begin
        for (int s = 0; s < 2; s++) begin
          mode = 2'(m); tmo = 2'(t); slow = 1'(s);
          tick();
          req = 1'b0;
          n = 0;
          do begin tick(); n++; end while (ent_vec() == 3'b000 && n < 400);
          thr = (t == 0) ? 0 : (t == 1) ? 64 : 128;
          chk(n == thr + 1, "R3 entry delay", n, thr + 1);
          chk(ent_vec() == kind(2'(m)), "R5 R6 R9 entry kind", ent_vec(), kind(2'(m)));
          chk(cke == 1'b1, "R12 cke high in entry cycle", cke, 1);
          tick();
          chk(cke == 1'b0, "R5 R6 R9 cke low", cke, 0);
          chk(ent_vec() == 3'b000, "R12 entry strobe one cycle", ent_vec(), 0);
          chk(clk_en == (m == 2), "R5 R6 R9 clock gating", clk_en, (m == 2));
          req = 1'b1;
          #0;
          chk(busy == 1'b1, "R7 R9 busy on request", busy, 1);
          if (m == 3) begin
            n = 0;
            for (int i = 0; i < 10; i++) begin
              tick();
              if (!busy || cke || ext_vec() != 3'b000) n++;
            end
            chk(n == 0, "R9 deep power-down holds", n, 0);
            mode = 2'd2;
            wake_seq(3'b001, 2);
          end else begin
            lat = (m == 2 && s == 1) ? 6 : 2;
            wake_seq(kind(2'(m)), lat);
          end
        end
      end
    end

    // R4: request mid countdown restarts it
    mode = 2'd1; tmo = 2'd1; slow = 1'b0;
    tick();
    req = 1'b0;
    n = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (ent_vec() != 3'b000) n++; end
    req = 1'b1; tick();
    if (ent_vec() != 3'b000) n++;
    chk(n == 0, "R4 no entry during countdown", n, 0);
    req = 1'b0;
    n = 0;
    do begin tick(); n++; end while (ent_vec() == 3'b000 && n < 400);
    chk(n == 65, "R4 countdown restarted", n, 65);
    tick();
    req = 1'b1;
    wake_seq(3'b100, 2);

    // R10
    frz = 1'b1; #1;
    chk(clk_en == 1'b0, "R10 clock frozen", clk_en, 0);
    frz = 1'b0; #1;
    chk(clk_en == 1'b1, "R10 clock released", clk_en, 1);
    // R11
    poff = 1'b1; tick();
    chk(cke == 1'b0, "R11 power-off cke", cke, 0);
    chk(busy == 1'b1, "R11 power-off busy", busy, 1);
    poff = 1'b0; tick();
    chk(cke == 1'b1, "R11 power-off released cke", cke, 1);
    chk(busy == 1'b0, "R11 power-off released busy", busy, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule